// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit sits beside the serial command engine of a small nonvolatile memory and decides, cycle by cycle, whether a write may reach the storage array or the status register. It holds two pieces of state. The first is a write-enable latch that is set and cleared by decoded commands. The second is a two-bit block-protect field that chooses how much of the top of the address space is locked. It combines these with the active-low hardware write-protect pin and the target address, and produces two registered permits and the status byte for reads.

The command engine raises single-cycle strobes for the enable and disable commands, for a status write (with its data byte), and for the end of a frame that carried a write. While it is shifting a data byte it holds `byte_active` high. Changes on the protect pin are taken in only while no byte is in flight, so the byte being shifted is never cut off halfway. The protect field models nonvolatile storage. A logic reset leaves it unchanged. Only the power-on reset clears it.

Top module: `wrprot_unit`

## Requirements
- R1: `status_byte` is {4'b0000, bp[1], bp[0], wel, 1'b0}: bits 7..4 and bit 0 always read zero, bits 3:2 hold the protect field, bit 1 holds the enable latch. It follows internal state with one register stage.
- R2: After `por` or `rst` the enable latch is 0, so `status_byte` bit 1 and both permits read 0.
- R3: `cmd_wren` sets the latch and `cmd_wrdi` clears it. When both arrive in the same cycle, the clear wins.
- R4: A status write never changes the latch. Only data bits 3:2 are stored, and bits 7..4, 1 and 0 of `st_data` have no effect.
- R5: `wr_frame_done` clears the latch and overrides `cmd_wren` in the same cycle. Any number of bytes may pass under `byte_active` without clearing it.
- R6: While the latch is 0 or the effective protect pin is low, `arr_wr_ok` and `st_wr_ok` are 0 and a status write leaves the protect field unchanged.
- R7: Protected ranges by field value: 00 none, 01 addresses 0x180..0x1FF, 10 addresses 0x100..0x1FF, 11 every address.
- R8: With the latch at 1 and the pin high, `st_wr_ok` is 1 and `arr_wr_ok` is 1 exactly for addresses outside the protected range.
- R9: The pin value is sampled only in cycles with `byte_active` low. A change during a byte acts once the byte ends.
- R10: `rst` leaves the protect field unchanged, and `por` clears it to 00.
- R11: `arr_wr_ok` reflects a new `addr` one clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous logic reset, active high |
| por | input | 1 | Synchronous power-on reset, active high, also clears the protect field |
| cmd_wren | input | 1 | Enable-command strobe |
| cmd_wrdi | input | 1 | Disable-command strobe |
| cmd_stwr | input | 1 | Status-write strobe |
| st_data | input | 8 | Data byte of the status write |
| wr_frame_done | input | 1 | End of a frame that carried a write |
| byte_active | input | 1 | High while a data byte is being shifted |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| addr | input | 9 | Target array address |
| status_byte | output | 8 | Status byte for reads |
| arr_wr_ok | output | 1 | Array write permitted |
| st_wr_ok | output | 1 | Status write permitted |

## Verification
A latch stuck high or left uncleared shows up on `status_byte` bit 1 two edges after the command, and on the permits in the same cycle. A mis-decoded protect range appears on `arr_wr_ok` one edge after the address is applied. The protect field only shows at the ports through the status byte, so every status write is read back. A reset that clears it in error, or a write that slips past the enable gate, appears there two edges later. An early pin sample appears on `arr_wr_ok` while `byte_active` is still high, which is why the pin is toggled in the middle of a byte.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int BP_W = 2;

  typedef enum logic [BP_W-1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_e;

  // top2 = two most significant address bits
  function automatic logic prot_hit(input prot_e sel, input logic [1:0] top2);
    case (sel)
      PROT_NONE:    prot_hit = 1'b0;
      PROT_QUARTER: prot_hit = (top2 == 2'b11);
      PROT_HALF:    prot_hit = top2[1];
      default:      prot_hit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/wp_wel.sv
module wp_wel (
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic set_i,
  input  logic clr_i,
  input  logic done_i,
  output logic wel_o
);
  always_ff @(posedge clk) begin
    if (rst || por)           wel_o <= 1'b0;
    else if (done_i || clr_i) wel_o <= 1'b0;
    else if (set_i)           wel_o <= 1'b1;
  end
endmodule

// File: rtl/wp_bpstore.sv
module wp_bpstore
  import wp_pkg::*;
(
  input  logic  clk,
  input  logic  por,
  input  logic  wr_i,
  input  prot_e d_i,
  output prot_e bp_o
);
  always_ff @(posedge clk) begin
    if (por)       bp_o <= PROT_NONE;
    else if (wr_i) bp_o <= d_i;
  end
endmodule

// File: rtl/wp_pinhold.sv
module wp_pinhold (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic busy_i,
  output logic eff_o
);
  always_ff @(posedge clk) begin
    if (rst)          eff_o <= 1'b0;
    else if (!busy_i) eff_o <= pin_n;
  end
endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import wp_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wel_i,
  input  logic          pin_ok_i,
  input  prot_e         bp_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] status_o,
  output logic          arr_ok_o,
  output logic          st_ok_o
);
  localparam int BP_LSB = 2;
  logic gate;
  logic hit;
  logic [DW-1:0] st_next;

  assign gate = wel_i & pin_ok_i;
  assign hit  = prot_hit(bp_i, addr_i[AW-1 -: 2]);

  always_comb begin
    st_next = '0;
    st_next[1] = wel_i;
    st_next[BP_LSB +: BP_W] = bp_i;
  end

  always_ff @(posedge clk) begin
    status_o <= st_next;
    if (rst) begin
      arr_ok_o <= 1'b0;
      st_ok_o  <= 1'b0;
    end else begin
      arr_ok_o <= gate & ~hit;
      st_ok_o  <= gate;
    end
  end
endmodule

// File: rtl/wrprot_unit.sv
module wrprot_unit
  import wp_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          por,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_stwr,
  input  logic [DW-1:0] st_data,
  input  logic          wr_frame_done,
  input  logic          byte_active,
  input  logic          wp_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] status_byte,
  output logic          arr_wr_ok,
  output logic          st_wr_ok
);
  localparam int BP_LSB = 2;

  logic  wel_q;
  logic  wp_eff;
  prot_e bp_q;
  logic  bp_wr;

  assign bp_wr = cmd_stwr & wel_q & wp_eff & ~rst;

  wp_wel u_wel (
    .clk(clk), .rst(rst), .por(por),
    .set_i(cmd_wren), .clr_i(cmd_wrdi), .done_i(wr_frame_done),
    .wel_o(wel_q)
  );

  wp_bpstore u_bp (
    .clk(clk), .por(por), .wr_i(bp_wr),
    .d_i(prot_e'(st_data[BP_LSB +: BP_W])),
    .bp_o(bp_q)
  );

  wp_pinhold u_pin (
    .clk(clk), .rst(rst), .pin_n(wp_n), .busy_i(byte_active),
    .eff_o(wp_eff)
  );

  wp_decide #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .wel_i(wel_q), .pin_ok_i(wp_eff),
    .bp_i(bp_q), .addr_i(addr),
    .status_o(status_byte), .arr_ok_o(arr_wr_ok), .st_ok_o(st_wr_ok)
  );
endmodule

// File: rtl/wp_checker.sv
module wp_checker (
  input logic       clk,
  input logic       rst,
  input logic       por,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_stwr,
  input logic       wr_frame_done,
  input logic       byte_active,
  input logic       wel_q,
  input logic       wp_eff,
  input logic [1:0] bp_q,
  input logic [7:0] status_byte,
  input logic       arr_wr_ok,
  input logic       st_wr_ok
);
  a_r1_fixed_zero: assert property (@(posedge clk) disable iff (rst || por)
    $past(rst || por) == 1'b0 |-> (status_byte[7:4] == 4'b0 && status_byte[0] == 1'b0));

  a_r3_set_latch: assert property (@(posedge clk) disable iff (rst || por)
    (cmd_wren && !cmd_wrdi && !wr_frame_done) |=> wel_q);

  a_r4_stwr_keeps_wel: assert property (@(posedge clk) disable iff (rst || por)
    (cmd_stwr && !cmd_wren && !cmd_wrdi && !wr_frame_done) |=> $stable(wel_q));

  a_r5_frame_clears: assert property (@(posedge clk) disable iff (rst || por)
    wr_frame_done |=> !wel_q);

  a_r6_gate_wel: assert property (@(posedge clk) disable iff (rst || por)
    !wel_q |=> (!st_wr_ok && !arr_wr_ok));

  a_r7_all_locked: assert property (@(posedge clk) disable iff (rst || por)
    (bp_q == 2'b11) |=> !arr_wr_ok);

  a_r9_pin_deferred: assert property (@(posedge clk) disable iff (rst || por)
    byte_active |=> $stable(wp_eff));

  a_r10_bp_survives: assert property (@(posedge clk) disable iff (por)
    rst |=> $stable(bp_q));
endmodule

bind wrprot_unit wp_checker u_chk (
  .clk(clk), .rst(rst), .por(por),
  .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_stwr(cmd_stwr),
  .wr_frame_done(wr_frame_done), .byte_active(byte_active),
  .wel_q(wel_q), .wp_eff(wp_eff), .bp_q(bp_q),
  .status_byte(status_byte), .arr_wr_ok(arr_wr_ok), .st_wr_ok(st_wr_ok)
);

// File: tb/sim_wrprot_unit.sv
module sim_wrprot_unit;
  logic clk = 1'b0;
  logic rst, por, cmd_wren, cmd_wrdi, cmd_stwr, wr_frame_done, byte_active, wp_n;
  logic [7:0] st_data;
  logic [8:0] addr;
  logic [7:0] status_byte;
  logic arr_wr_ok, st_wr_ok;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wrprot_unit u0 (.*);

  // vector: {bp[1:0], addr[8:0], expected arr_wr_ok}  (R7, R8)
  localparam logic [11:0] VEC [12] = '{
    {2'b00, 9'h1FF, 1'b1}, {2'b01, 9'h17F, 1'b1}, {2'b01, 9'h180, 1'b0},
    {2'b01, 9'h1FF, 1'b0}, {2'b10, 9'h0FF, 1'b1}, {2'b10, 9'h100, 1'b0},
    {2'b11, 9'h000, 1'b0}, {2'b11, 9'h0FF, 1'b0}, {2'b00, 9'h000, 1'b1},
    {2'b10, 9'h17F, 1'b0}, {2'b01, 9'h000, 1'b1}, {2'b11, 9'h1FF, 1'b0}
  };

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cmd_wren = 0; cmd_wrdi = 0; cmd_stwr = 0; wr_frame_done = 0;
      rst = 0; por = 0;
    end
  endtask

  task automatic set_status(input logic [7:0] d);
    cmd_wren = 1; tick();
    cmd_stwr = 1; st_data = d; tick();
    wr_frame_done = 1; tick();
    tick(2);
  endtask

  initial begin
    #100000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1; por = 1; cmd_wren = 0; cmd_wrdi = 0; cmd_stwr = 0;
    wr_frame_done = 0; byte_active = 0; wp_n = 1; st_data = 0; addr = 0;
    @(posedge clk); #1; rst = 1; por = 1;
    tick(); tick(3);
    check("R2 reset status", status_byte, 8'h00);
    check("R2 reset arr permit", arr_wr_ok, 0);
    check("R2 reset st permit", st_wr_ok, 0);

    // table walk
    foreach (VEC[i]) begin
      set_status({4'hF, VEC[i][11:10], 2'b11});
      cmd_wren = 1; addr = VEC[i][9:1]; tick(); tick(2);
      check("R7 range", arr_wr_ok, VEC[i][0]);
      check("R1 status after table write", status_byte, {4'h0, VEC[i][11:10], 2'b10});
      check("R8 st permit", st_wr_ok, 1);
      cmd_wrdi = 1; tick(); tick(2);
    end

    // R3: wren / wrdi / both
    set_status(8'h00);
    cmd_wren = 1; tick(); tick();
    check("R3 wren sets", status_byte, 8'h02);
    cmd_wrdi = 1; tick(); tick();
    check("R3 wrdi clears", status_byte, 8'h00);
    cmd_wren = 1; cmd_wrdi = 1; tick(); tick();
    check("R3 clear wins", status_byte, 8'h00);

    // R4: status write keeps latch, ignores other bits
    cmd_wren = 1; tick();
    cmd_stwr = 1; st_data = 8'hF7; tick(); tick();
    check("R4 latch kept, only bits 3:2 stored", status_byte, 8'h06);

    // R5: bytes in a burst do not clear, frame end does and beats wren
    set_status(8'h00);
    cmd_wren = 1; addr = 9'h010; tick();
    for (int b = 0; b < 3; b++) begin
      byte_active = 1; tick(8); byte_active = 0; tick();
    end
    tick();
    check("R5 burst keeps latch", status_byte, 8'h02);
    check("R5 burst permit", arr_wr_ok, 1);
    wr_frame_done = 1; cmd_wren = 1; tick(); tick();
    check("R5 frame end clears", status_byte, 8'h00);

    // R6: latch low blocks status write
    cmd_stwr = 1; st_data = 8'h0C; tick(); tick(2);
    check("R6 no latch status ignored", status_byte, 8'h00);
    check("R6 no latch arr permit", arr_wr_ok, 0);
    // R6: pin low blocks
    cmd_wren = 1; wp_n = 0; tick(); tick(2);
    check("R6 pin low arr permit", arr_wr_ok, 0);
    check("R6 pin low st permit", st_wr_ok, 0);
    cmd_stwr = 1; st_data = 8'h0C; tick(); tick(2);
    check("R6 pin low status ignored", status_byte, 8'h02);
    wp_n = 1; tick(3);

    // R9: pin change during a byte deferred
    check("R9 pre permit", arr_wr_ok, 1);
    byte_active = 1; tick(); wp_n = 0; tick(4);
    check("R9 held during byte", arr_wr_ok, 1);
    byte_active = 0; tick();
    check("R9 one edge after byte still old", arr_wr_ok, 1);
    tick();
    check("R9 takes effect after byte", arr_wr_ok, 0);
    wp_n = 1; tick(3);

    // R11: address latency
    set_status(8'h04);
    cmd_wren = 1; addr = 9'h000; tick(); tick(2);
    check("R11 low addr permitted", arr_wr_ok, 1);
    addr = 9'h180; tick();
    check("R11 one edge after addr", arr_wr_ok, 0);
    addr = 9'h17F; tick();
    check("R11 back below range", arr_wr_ok, 1);

    // R10: bp survives rst, cleared by por
    set_status(8'h08);
    rst = 1; tick(); tick(2);
    check("R10 bp kept over rst", status_byte, 8'h08);
    check("R2 rst clears latch permit", st_wr_ok, 0);
    por = 1; tick(); tick(2);
    check("R10 por clears bp", status_byte, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule